// File: doc/BRIEF.md
# ISA Multi-Device I/O Address Decoder

This block sits behind the 8-bit ISA data path of a multi-function sound peripheral that presents seven logical devices to the host: a wave-audio codec (0), a synthesizer (1), a legacy sound-card-compatible device (2), a game port (3), a control device (4), a MIDI interface (5) and a CD-ROM interface (6). Each device is given a base address, an enable and a window of registers sized by a parameter. On every bus cycle the block compares the address with each live device. The codec and control devices compare twelve address bits. The other five compare ten bits and demand that bits 11 and 10 be zero. The match is then qualified with AEN and the DMA acknowledges. The block produces a one-hot device select and the register offset inside the window.

For reads, the block steers the selected device's register data onto the bus outputs and raises the tri-state enable while the read strobe is low. For writes, it watches the write strobe, which is active low. When the strobe returns high it latches the bus byte with the select and offset, and presents them as a one-cycle strobe to the device logic. An optional wide mode makes every device also require address bits 15..12 to be zero. Because the CD-ROM pins carry those bits in this mode, the CD-ROM device is switched off. Base registers and enables arrive as plain inputs from configuration logic elsewhere.

Top module: `isa_io_decoder`

## Requirements
- R1: A 12-bit device (indices 0 and 4) matches when address bits 11..W equal its base bits 11..W, W being its window width in bits (defaults: dev0 3, dev1 2, dev2 4, dev3 3, dev4 3, dev5 1, dev6 2); `reg_offset` then equals address bits W-1..0, zero-extended.
- R2: A 10-bit device (indices 1, 2, 3, 5, 6) matches only when address bits 11 and 10 are both zero and address bits 9..W equal its base bits 9..W; base bits 11..10 are ignored.
- R3: With `wide_decode` high, no device matches unless address bits 15..12 are all zero; with it low, those bits have no effect on the decode.
- R4: With `wide_decode` high, device 6 (CD-ROM) is never selected, whatever its enable and base.
- R5: A device whose bit in `dev_en` is low is never selected and never drives or captures data.
- R6: While `aen` is high or any `dma_ack` bit is high, `dev_sel` is all zero, `sd_oe` is low and no write strobe is produced.
- R7: `dev_sel` is zero or one-hot; when several live devices match, the lowest index is selected.
- R8: `overlap_seen` rises one clock after an edge that samples a qualified cycle (aen low, no DMA acknowledge) in which two or more devices match, and stays high until reset.
- R9: `sd_oe` is high exactly when `ior_n` is low and `dev_sel` is non-zero; `sd_out` then carries the selected device's byte from `rd_data` (device i at bits 8i+7..8i) and is zero otherwise.
- R10: At the clock edge that first samples `iow_n` high after an edge that sampled it low, if the cycle is valid, `wr_stb` is high for the following clock cycle only, with `wr_data` = `sd_in`, `wr_sel` = `dev_sel` and `wr_offset` = `reg_offset`, all as sampled at that edge.
- R11: After synchronous reset (`rst_n` low at a clock edge), `wr_stb`, `wr_data`, `wr_sel`, `wr_offset` and `overlap_seen` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | ISA address bits 15..0 |
| aen | input | 1 | Address enable; high marks a DMA cycle |
| dma_ack | input | 4 | DMA acknowledges, active high |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| sd_in | input | 8 | Data bus as seen by the receiver |
| sd_out | output | 8 | Data to the bus driver |
| sd_oe | output | 1 | Tri-state enable of the bus driver |
| wide_decode | input | 1 | High selects 16-bit decode and turns off the CD-ROM device |
| dev_en | input | 7 | Per-device enable |
| dev_base | input | 84 | Per-device base, 12 bits each, device i at bits 12i+11..12i |
| rd_data | input | 56 | Per-device read byte for the current offset |
| dev_sel | output | 7 | One-hot device select of the current cycle |
| reg_offset | output | 4 | Register offset inside the selected window |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_data | output | 8 | Latched write byte |
| wr_sel | output | 7 | Device select latched with the write |
| wr_offset | output | 4 | Offset latched with the write |
| overlap_seen | output | 1 | Sticky flag: two devices claimed one qualified cycle |

## Verification
The bench sweeps all 4096 low addresses under several enable masks and wide-mode settings, with different upper nibbles, and predicts every select, offset and read byte from base arithmetic. This exposes a 10-bit device that aliases into 0x400..0xFFF, a comparator that uses bits below the window, a wide mode that leaves upper bits unchecked, and a CD-ROM device that stays live in wide mode. Separate cases hold a matching address while raising AEN or each DMA acknowledge in turn. A design that ignores one of these would drive the bus during DMA. The bench also checks write capture at the strobe's release; a design that latches on the falling edge, or for too long, gives the wrong byte or a stretched strobe. A deliberate overlap checks that the lower index wins and that the sticky flag neither misses the event nor clears by itself.

// File: rtl/isa_dec_pkg.sv
// Package isa_dec_pkg
// Shared widths and types for the ISA I/O decoder. Assumes an 8-bit data
// path and a 16-bit I/O address, of which 12 bits form the decode space.
package isa_dec_pkg;
    localparam int ADDR_W  = 16;
    localparam int SPACE_W = 12;
    localparam int DATA_W  = 8;

    typedef logic [ADDR_W-1:0]  bus_addr_t;
    typedef logic [SPACE_W-1:0] space_addr_t;
    typedef logic [DATA_W-1:0]  bus_byte_t;
endpackage

// File: rtl/isa_dev_match.sv
// Module isa_dev_match
// Address comparator for one logical device. It compares the bits above the
// window with the base. A 10-bit device also demands zero in bits 11..10. In
// wide mode the upper nibble must be zero, and a device marked DROP_IN_WIDE
// turns off. Assumes WIN >= 1, WIN <= OFF_W and a base aligned to the window.
module isa_dev_match
    import isa_dec_pkg::*;
#(
    parameter int WIN          = 3,
    parameter bit DEC12        = 1'b0,
    parameter bit DROP_IN_WIDE = 1'b0,
    parameter int OFF_W        = 4
) (
    input  bus_addr_t          addr,
    input  space_addr_t        base,
    input  logic               en,
    input  logic               wide16,
    output logic               hit,
    output logic [OFF_W-1:0]   offset
);
    localparam space_addr_t CMP_MASK  = space_addr_t'({SPACE_W{1'b1}} << WIN);
    localparam space_addr_t SPAN_MASK = DEC12 ? space_addr_t'(12'hFFF) : space_addr_t'(12'h3FF);

    space_addr_t base_eff;
    space_addr_t diff;
    space_addr_t low_bits;
    logic        upper_ok;
    logic        live;

    // Compare the address against the effective base above the window.
    always_comb begin
        base_eff = base & SPAN_MASK;
        diff     = (addr[SPACE_W-1:0] ^ base_eff) & CMP_MASK;
        upper_ok = !wide16 || (addr[ADDR_W-1:SPACE_W] == '0);
        live     = en && !(DROP_IN_WIDE && wide16);
        hit      = live && upper_ok && (diff == '0);
    end

    // Extract the register offset from the bits inside the window.
    always_comb begin
        low_bits = addr[SPACE_W-1:0] & ~CMP_MASK;
        offset   = low_bits[OFF_W-1:0];
    end
endmodule

// File: rtl/isa_sel_arbiter.sv
// Module isa_sel_arbiter
// Qualifies the per-device hits with AEN and the DMA acknowledges, grants the
// lowest-index hit, muxes its offset and keeps a sticky overlap flag.
// Assumes the hit vector is combinational from the current bus state.
module isa_sel_arbiter #(
    parameter int NUM_DEV  = 7,
    parameter int NUM_DACK = 4,
    parameter int OFF_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_DEV-1:0]        raw_hit,
    input  logic [NUM_DEV*OFF_W-1:0]  raw_off,
    input  logic                      aen,
    input  logic [NUM_DACK-1:0]       dma_ack,
    output logic [NUM_DEV-1:0]        sel,
    output logic [OFF_W-1:0]          off,
    output logic                      overlap_q
);
    logic               qual;
    logic [NUM_DEV-1:0] grant;
    logic               clash;

    // Pick the lowest set hit and gate it with cycle qualification.
    always_comb begin
        qual  = !aen && (dma_ack == '0);
        grant = raw_hit & (~raw_hit + NUM_DEV'(1));
        sel   = qual ? grant : '0;
        clash = qual && ((raw_hit & ~grant) != '0);
    end

    // Route the offset of the granted device.
    always_comb begin
        off = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (sel[i]) off = off | raw_off[i*OFF_W +: OFF_W];
        end
    end

    // Sticky record of any qualified cycle claimed by more than one device.
    always_ff @(posedge clk) begin
        if (!rst_n)     overlap_q <= 1'b0;
        else if (clash) overlap_q <= 1'b1;
    end

    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    p_sel_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != '0) |-> ((sel - NUM_DEV'(1)) & raw_hit) == '0);
    p_dma_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (aen || (dma_ack != '0)) |-> (sel == '0));
    p_overlap_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_q |=> overlap_q);
endmodule

// File: rtl/isa_wr_capture.sv
// Module isa_wr_capture
// Detects the release of the active-low write strobe on the block clock and
// latches the data byte, the select and the offset at that edge. Assumes the
// address and data stay stable through the strobe release.
module isa_wr_capture
    import isa_dec_pkg::*;
#(
    parameter int NUM_DEV = 7,
    parameter int OFF_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iow_n,
    input  bus_byte_t          sd_in,
    input  logic [NUM_DEV-1:0] sel,
    input  logic [OFF_W-1:0]   off,
    output logic               wr_stb,
    output bus_byte_t          wr_data,
    output logic [NUM_DEV-1:0] wr_sel,
    output logic [OFF_W-1:0]   wr_offset
);
    logic iow_q;
    logic release_now;

    // Remember the strobe level of the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) iow_q <= 1'b1;
        else        iow_q <= iow_n;
    end

    // A low-to-high transition of the strobe with a live select.
    always_comb release_now = iow_n && !iow_q && (sel != '0);

    // Latch the write and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb    <= 1'b0;
            wr_data   <= '0;
            wr_sel    <= '0;
            wr_offset <= '0;
        end else begin
            wr_stb <= release_now;
            if (release_now) begin
                wr_data   <= sd_in;
                wr_sel    <= sel;
                wr_offset <= off;
            end
        end
    end

    p_wr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    p_wr_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $onehot(wr_sel));
endmodule

// File: rtl/isa_io_decoder.sv
// Module isa_io_decoder
// Top of the ISA I/O decoder: one comparator per logical device, a priority
// arbiter with cycle qualification, the read data steering with bus enable,
// and write capture. Device order fixes priority; CD_IDX names the device
// whose pins the wide decode mode takes over.
module isa_io_decoder
    import isa_dec_pkg::*;
#(
    parameter int                      NUM_DEV    = 7,
    parameter int                      NUM_DACK   = 4,
    parameter int                      OFF_W      = 4,
    parameter logic [NUM_DEV-1:0]      DEC12_MASK = 7'b0010001,
    parameter logic [NUM_DEV*4-1:0]    WIN_BITS   = {4'd2, 4'd1, 4'd3, 4'd3, 4'd4, 4'd2, 4'd3},
    parameter int                      CD_IDX     = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [15:0]                 bus_addr,
    input  logic                        aen,
    input  logic [NUM_DACK-1:0]         dma_ack,
    input  logic                        ior_n,
    input  logic                        iow_n,
    input  logic [7:0]                  sd_in,
    output logic [7:0]                  sd_out,
    output logic                        sd_oe,
    input  logic                        wide_decode,
    input  logic [NUM_DEV-1:0]          dev_en,
    input  logic [NUM_DEV*SPACE_W-1:0]  dev_base,
    input  logic [NUM_DEV*DATA_W-1:0]   rd_data,
    output logic [NUM_DEV-1:0]          dev_sel,
    output logic [OFF_W-1:0]            reg_offset,
    output logic                        wr_stb,
    output logic [7:0]                  wr_data,
    output logic [NUM_DEV-1:0]          wr_sel,
    output logic [OFF_W-1:0]            wr_offset,
    output logic                        overlap_seen
);
    logic [NUM_DEV-1:0]       raw_hit;
    logic [NUM_DEV*OFF_W-1:0] raw_off;
    bus_byte_t                mux_byte;

    // One comparator per device, each with its own window and decode width.
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        isa_dev_match #(
            .WIN          (int'(WIN_BITS[g*4 +: 4])),
            .DEC12        (DEC12_MASK[g]),
            .DROP_IN_WIDE (g == CD_IDX),
            .OFF_W        (OFF_W)
        ) u_match (
            .addr   (bus_addr),
            .base   (dev_base[g*SPACE_W +: SPACE_W]),
            .en     (dev_en[g]),
            .wide16 (wide_decode),
            .hit    (raw_hit[g]),
            .offset (raw_off[g*OFF_W +: OFF_W])
        );
    end

    isa_sel_arbiter #(
        .NUM_DEV  (NUM_DEV),
        .NUM_DACK (NUM_DACK),
        .OFF_W    (OFF_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_hit   (raw_hit),
        .raw_off   (raw_off),
        .aen       (aen),
        .dma_ack   (dma_ack),
        .sel       (dev_sel),
        .off       (reg_offset),
        .overlap_q (overlap_seen)
    );

    // Steer the selected device's byte towards the bus driver.
    always_comb begin
        mux_byte = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (dev_sel[i]) mux_byte = mux_byte | rd_data[i*DATA_W +: DATA_W];
        end
    end

    // Drive the bus only while reading a claimed address.
    always_comb begin
        sd_oe  = !ior_n && (dev_sel != '0);
        sd_out = sd_oe ? mux_byte : '0;
    end

    isa_wr_capture #(
        .NUM_DEV (NUM_DEV),
        .OFF_W   (OFF_W)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .iow_n     (iow_n),
        .sd_in     (sd_in),
        .sel       (dev_sel),
        .off       (reg_offset),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .wr_sel    (wr_sel),
        .wr_offset (wr_offset)
    );

    p_oe_needs_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> (!ior_n && (dev_sel != '0)));
    p_disabled_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel & ~dev_en) == '0);
    p_cd_off_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wide_decode |-> !dev_sel[CD_IDX]);
    p_upper_zero_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_decode && (bus_addr[15:12] != 4'h0)) |-> (dev_sel == '0));
    p_no_write_in_dma_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (aen || (dma_ack != '0)) |=> !wr_stb);
endmodule

// File: tb/tb_isa_io_decoder.sv
`timescale 1ns/1ps
module tb_isa_io_decoder;
    localparam int ND = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        aen = 1'b0;
    logic [3:0]  dma_ack = '0;
    logic        ior_n = 1'b1;
    logic        iow_n = 1'b1;
    logic [7:0]  sd_in = '0;
    logic [7:0]  sd_out;
    logic        sd_oe;
    logic        wide_decode = 1'b0;
    logic [6:0]  dev_en = 7'h7F;
    logic [83:0] dev_base;
    logic [55:0] rd_data;
    logic [6:0]  dev_sel;
    logic [3:0]  reg_offset;
    logic        wr_stb;
    logic [7:0]  wr_data;
    logic [6:0]  wr_sel;
    logic [3:0]  wr_offset;
    logic        overlap_seen;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int          win_tab [ND] = '{3, 2, 4, 3, 3, 1, 2};
    bit          d12_tab [ND] = '{1, 0, 0, 0, 1, 0, 0};
    logic [11:0] base_tab[ND] = '{12'h530, 12'h388, 12'h220, 12'h200, 12'h538, 12'h330, 12'h1E0};

    always #2 clk = ~clk;

    isa_io_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .aen(aen), .dma_ack(dma_ack),
        .ior_n(ior_n), .iow_n(iow_n), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
        .wide_decode(wide_decode), .dev_en(dev_en), .dev_base(dev_base), .rd_data(rd_data),
        .dev_sel(dev_sel), .reg_offset(reg_offset), .wr_stb(wr_stb), .wr_data(wr_data),
        .wr_sel(wr_sel), .wr_offset(wr_offset), .overlap_seen(overlap_seen)
    );

    always_comb begin
        for (int i = 0; i < ND; i++) begin
            dev_base[i*12 +: 12] = base_tab[i];
            rd_data[i*8 +: 8]    = 8'(8'h11 * (i + 1));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference: index of the expected device, or -1.
    function automatic int exp_dev(input logic [15:0] a, input bit wide, input logic [6:0] en);
        for (int i = 0; i < ND; i++) begin
            int w;
            bit h;
            w = win_tab[i];
            if (!en[i]) continue;
            if (wide && i == 6) continue;
            if (wide && a[15:12] != 4'h0) continue;
            if (d12_tab[i]) h = (int'(a[11:0]) >> w) == (int'(base_tab[i]) >> w);
            else h = (a[11:10] == 2'b00) && ((int'(a[9:0]) >> w) == (int'(base_tab[i][9:0]) >> w));
            if (h) return i;
        end
        return -1;
    endfunction

    task automatic sweep(input bit wide, input logic [3:0] upper, input logic [6:0] en, input string req);
        wide_decode = wide;
        dev_en = en;
        ior_n = 1'b0;
        for (int a = 0; a < 4096; a++) begin
            int e;
            int es;
            bus_addr = {upper, 12'(a)};
            #1;
            e = exp_dev(bus_addr, wide, en);
            es = (e < 0) ? 0 : (1 << e);
            chk(dev_sel == 7'(es), req, dev_sel, es);
            chk(sd_oe == (e >= 0), {req, " R9"}, sd_oe, e >= 0);
            if (e >= 0) begin
                int eo;
                eo = a & ((1 << win_tab[e]) - 1);
                chk(reg_offset == 4'(eo), {req, " R1 R2 offset"}, reg_offset, eo);
                chk(sd_out == 8'(8'h11 * (e + 1)), "R9 read byte", sd_out, 8'h11 * (e + 1));
            end else begin
                chk(sd_out == 8'h00, "R9 idle byte", sd_out, 0);
            end
        end
        ior_n = 1'b1;
    endtask

    // Write at addr with data d; expect a strobe if exp_ok.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input bit exp_ok,
                            input int e_dev, input int e_off, input string req);
        @(negedge clk);
        bus_addr = a;
        sd_in = d;
        iow_n = 1'b0;
        @(negedge clk);
        chk(wr_stb == 1'b0, {req, " no strobe while low"}, wr_stb, 0);
        iow_n = 1'b1;
        @(negedge clk);
        chk(wr_stb == exp_ok, {req, " strobe"}, wr_stb, exp_ok);
        if (exp_ok) begin
            chk(wr_data == d, {req, " data"}, wr_data, d);
            chk(wr_sel == 7'(1 << e_dev), {req, " sel"}, wr_sel, 1 << e_dev);
            chk(wr_offset == 4'(e_off), {req, " offset"}, wr_offset, e_off);
        end
        @(negedge clk);
        chk(wr_stb == 1'b0, {req, " single cycle"}, wr_stb, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(wr_stb == 0, "R11 wr_stb", wr_stb, 0);
        chk(wr_data == 0, "R11 wr_data", wr_data, 0);
        chk(wr_sel == 0, "R11 wr_sel", wr_sel, 0);
        chk(wr_offset == 0, "R11 wr_offset", wr_offset, 0);
        chk(overlap_seen == 0, "R11 overlap", overlap_seen, 0);
        rst_n = 1'b1;
        @(negedge clk);

        sweep(1'b0, 4'h0, 7'h7F, "R1 R2 R7 base");
        sweep(1'b0, 4'hA, 7'h7F, "R3 upper ignored");
        sweep(1'b1, 4'h0, 7'h7F, "R3 R4 wide");
        sweep(1'b1, 4'h5, 7'h7F, "R3 wide upper");
        sweep(1'b0, 4'h0, 7'b1010101, "R5 mask a");
        sweep(1'b0, 4'h0, 7'b0101010, "R5 mask b");
        wide_decode = 1'b0;
        dev_en = 7'h7F;

        // R6: qualification by aen and each DMA acknowledge
        @(negedge clk);
        bus_addr = 16'h0225;
        ior_n = 1'b0;
        #1 chk(dev_sel == 7'b0000100, "R6 baseline", dev_sel, 7'b0000100);
        aen = 1'b1;
        #1 chk(dev_sel == 0 && sd_oe == 0, "R6 aen", {dev_sel, sd_oe}, 0);
        aen = 1'b0;
        for (int k = 0; k < 4; k++) begin
            dma_ack = 4'(1 << k);
            #1 chk(dev_sel == 0 && sd_oe == 0, "R6 dack", {dev_sel, sd_oe}, 0);
        end
        dma_ack = '0;
        ior_n = 1'b1;
        #1 chk(sd_oe == 0, "R9 no read strobe", sd_oe, 0);

        // R10 writes
        do_write(16'h0203, 8'h5C, 1'b1, 3, 3, "R10 game");
        do_write(16'h0535, 8'hA7, 1'b1, 0, 5, "R10 codec");
        do_write(16'h0622, 8'h33, 1'b0, 0, 0, "R2 R10 alias");
        aen = 1'b1;
        do_write(16'h0203, 8'h99, 1'b0, 0, 0, "R6 R10 aen");
        aen = 1'b0;
        dma_ack = 4'b0100;
        do_write(16'h0331, 8'h44, 1'b0, 0, 0, "R6 R10 dack");
        dma_ack = '0;
        dev_en = 7'b1011111;
        do_write(16'h0331, 8'h44, 1'b0, 0, 0, "R5 R10 disabled");
        dev_en = 7'h7F;
        do_write(16'h0331, 8'h44, 1'b1, 5, 1, "R10 midi");

        // R8 overlap: ctrl base moved onto codec
        base_tab[4] = 12'h530;
        @(negedge clk);
        aen = 1'b1;
        bus_addr = 16'h0531;
        @(negedge clk);
        @(negedge clk);
        chk(overlap_seen == 0, "R8 not set in dma", overlap_seen, 0);
        aen = 1'b0;
        #1 chk(dev_sel == 7'b0000001, "R7 lowest wins", dev_sel, 1);
        chk(overlap_seen == 0, "R8 before edge", overlap_seen, 0);
        @(negedge clk);
        chk(overlap_seen == 1, "R8 set", overlap_seen, 1);
        bus_addr = 16'h0000;
        repeat (3) @(negedge clk);
        chk(overlap_seen == 1, "R8 sticky", overlap_seen, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(overlap_seen == 0, "R11 overlap cleared", overlap_seen, 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule